// File: doc/BRIEF.md
# RTC Shadow-Register Update Controller

This block stands between a byte-wide host register port and the live time and alarm registers of a real-time clock. The host programs time and alarm values into staging (shadow) bytes. Nothing it writes reaches the live registers until it sets a commit bit in the update-control register. A prescaled delay timer then runs for one of two selectable lengths. When the count expires, the staged bytes are copied on a single clock edge and the commit bit clears itself.

A second bit in the same register takes a snapshot of the running calendar value (a counter input here) into the host-readable time bytes. A bulk read of those bytes therefore returns one coherent image. Alarm commits have their own bit. A parameter chooses whether hardware clears that bit on completion or the host must write it back to zero. A time-enable bit gates whether a time commit actually loads the live time. A small control register holds a BCD-format flag and a 24-hour flag.

The byte image is ordered seconds, minutes, hours, weekday, date, month, year-low, year-high, with byte i carried on bits [8i+7:8i] of every wide bus.

Top module: `rtc_shadow_sync`

## Requirements
- R1: After reset the update-control register (address 16) and control register (address 17) read 0. `time_load_o` and `alarm_load_o` are 0, and `time_value_o` and `alarm_value_o` are all zero.
- R2: Bytes written to the time staging addresses 0..NBYTES-1 do not change `time_value_o` until a time commit completes.
- R3: Writing address 16 with bit 0 set starts a time transfer. Bit 0 reads 1 for the whole transfer and reads 0 from the cycle after the commit edge.
- R4: The commit edge comes exactly DLY_LONG×PRESC_DIV cycles after the request edge when bit 4 of the request write is 0, and DLY_SHORT×PRESC_DIV cycles when bit 4 is 1. In the cycle after the commit edge `time_load_o` is high for exactly one cycle and `time_value_o` equals the staged bytes.
- R5: A time transfer loads the live time only if bit 3 (time-enable) was 1 in the request. Otherwise the transfer completes with no `time_load_o` pulse and `time_value_o` unchanged.
- R6: Writing address 16 with bit 2 set commits the alarm staging bytes to `alarm_value_o`, with a one-cycle `alarm_load_o` pulse and the same delay rules as R4. With ALARM_AUTOCLEAR=1, bit 2 reads 0 after the commit. With ALARM_AUTOCLEAR=0 it stays 1 until the host writes address 16 with bit 2 clear.
- R7: While a transfer is in flight, writes to address 16 neither restart the delay nor add a time or alarm commit.
- R8: Writing address 16 with bit 1 set captures `live_time_i` as sampled on that write edge into the bytes read at addresses 0..NBYTES-1. Bit 1 always reads 0.
- R9: The captured snapshot stays unchanged between read-update requests while `live_time_i` keeps moving.
- R10: At address 17, bit 0 (BCD enable) and bit 1 (24-hour) are writable, read back, and drive `bcd_en_o` and `hour24_o`.
- R11: Alarm staging byte i reads back at address 8+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 5 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr` (combinational) |
| live_time_i | input | NBYTES×8 | Running calendar value from the counter stub |
| time_load_o | output | 1 | One-cycle pulse when live time is loaded |
| time_value_o | output | NBYTES×8 | Live time value to load into the calendar |
| alarm_load_o | output | 1 | One-cycle pulse when live alarm is loaded |
| alarm_value_o | output | NBYTES×8 | Live alarm registers |
| bcd_en_o | output | 1 | BCD format enable |
| hour24_o | output | 1 | 24-hour mode |

## Verification
The hardest situation to reach is a second commit request that lands partway through an active delay. It is only visible as something that fails to happen: no restarted delay and no extra alarm load. The stimulus starts a short transfer, and five cycles later writes a request carrying both commit bits. It then checks that the original commit edge is unchanged, that the alarm bit never reads 1, and that no alarm pulse appears. A second instance built with manual alarm clearing shares the stimulus, so the sticky alarm bit and its software clear can be observed alongside the self-clearing variant.

// File: rtl/rtc_sync_pkg.sv
package rtc_sync_pkg;

    localparam int ADDR_W     = 5;
    localparam int BYTE_W     = 8;
    localparam int MAX_BYTES  = 8;

    localparam logic [ADDR_W-1:0] UPD_ADDR  = 5'd16;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'd17;

    // Update-control byte, bit 0 in the least significant position
    typedef struct packed {
        logic fast;     // bit 4: short delay
        logic time_en;  // bit 3: allow time load
        logic alm;      // bit 2: alarm commit
        logic rd;       // bit 1: snapshot request
        logic wr;       // bit 0: time commit
    } upd_reg_t;

    typedef struct packed {
        logic h24;      // bit 1
        logic bcd;      // bit 0
    } ctrl_reg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TIME,
        SEL_ALARM,
        SEL_UPD,
        SEL_CTRL
    } reg_sel_t;

    typedef struct packed {
        reg_sel_t   sel;
        logic [2:0] idx;
    } dec_t;

    function automatic dec_t decode_addr(input logic [ADDR_W-1:0] a, input int nbytes);
        dec_t d;
        d.sel = SEL_NONE;
        d.idx = a[2:0];
        if (a[4:3] == 2'b00) begin
            if (int'(a[2:0]) < nbytes) d.sel = SEL_TIME;
        end else if (a[4:3] == 2'b01) begin
            if (int'(a[2:0]) < nbytes) d.sel = SEL_ALARM;
        end else if (a == UPD_ADDR) begin
            d.sel = SEL_UPD;
        end else if (a == CTRL_ADDR) begin
            d.sel = SEL_CTRL;
        end
        return d;
    endfunction

endpackage

// File: rtl/rtc_xfer_timer.sv
module rtc_xfer_timer
    import rtc_sync_pkg::*;
#(
    parameter int PRESC_DIV = 2,
    parameter int DLY_LONG  = 240,
    parameter int DLY_SHORT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic fast_sel,
    output logic done
);

    localparam int PW      = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam int DLY_MAX = (DLY_LONG > DLY_SHORT) ? DLY_LONG : DLY_SHORT;
    localparam int CW      = $clog2(DLY_MAX + 1);

    logic          run;
    logic [PW-1:0] presc;
    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (presc == PW'(PRESC_DIV - 1));
    assign done = tick && (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            presc <= '0;
            cnt   <= '0;
        end else if (start) begin
            run   <= 1'b1;
            presc <= '0;
            cnt   <= fast_sel ? CW'(DLY_SHORT) : CW'(DLY_LONG);
        end else if (run) begin
            presc <= tick ? '0 : presc + 1'b1;
            if (tick) cnt <= cnt - 1'b1;
            if (done) run <= 1'b0;
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);                                         // R7
    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt != '0));                                    // R4

endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
    import rtc_sync_pkg::*;
#(
    parameter int NBYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  dec_t                     dec,
    input  logic [BYTE_W-1:0]        wdata,
    input  logic                     snap_en,
    input  logic                     commit_time,
    input  logic                     commit_alarm,
    input  logic [NBYTES*BYTE_W-1:0] live_time_i,
    output logic [NBYTES*BYTE_W-1:0] time_value_o,
    output logic [NBYTES*BYTE_W-1:0] alarm_value_o,
    output logic [BYTE_W-1:0]        snap_byte,
    output logic [BYTE_W-1:0]        alarm_byte
);

    logic [NBYTES-1:0][BYTE_W-1:0] tshadow;
    logic [NBYTES-1:0][BYTE_W-1:0] ashadow;
    logic [NBYTES-1:0][BYTE_W-1:0] snap;
    logic [NBYTES-1:0][BYTE_W-1:0] tlive;
    logic [NBYTES-1:0][BYTE_W-1:0] alive;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst) begin
                tshadow[b] <= '0;
                ashadow[b] <= '0;
                snap[b]    <= '0;
            end else begin
                if (we && dec.sel == SEL_TIME && dec.idx == 3'(b))
                    tshadow[b] <= wdata;
                if (we && dec.sel == SEL_ALARM && dec.idx == 3'(b))
                    ashadow[b] <= wdata;
                if (snap_en)
                    snap[b] <= live_time_i[b*BYTE_W +: BYTE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tlive <= '0;
            alive <= '0;
        end else begin
            if (commit_time)  tlive <= tshadow;
            if (commit_alarm) alive <= ashadow;
        end
    end

    assign time_value_o  = tlive;
    assign alarm_value_o = alive;

    always_comb begin
        snap_byte  = '0;
        alarm_byte = '0;
        if (int'(dec.idx) < NBYTES) begin
            snap_byte  = snap[dec.idx];
            alarm_byte = ashadow[dec.idx];
        end
    end

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !snap_en |=> $stable(snap));                             // R9
    AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !commit_time |=> $stable(tlive));                        // R2

endmodule

// File: rtl/rtc_upd_ctrl.sv
module rtc_upd_ctrl
    import rtc_sync_pkg::*;
#(
    parameter bit ALARM_AUTOCLEAR = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      upd_we,
    input  upd_reg_t  upd_wdata,
    input  logic      ctrl_we,
    input  ctrl_reg_t ctrl_wdata,
    input  logic      done,
    output logic      start,
    output logic      snap_en,
    output logic      commit_time,
    output logic      commit_alarm,
    output upd_reg_t  upd_q,
    output ctrl_reg_t ctrl_q,
    output logic      time_load_o,
    output logic      alarm_load_o
);

    logic busy;
    logic wr_flag;
    logic alm_flag;
    logic ten;
    logic fast_q;
    logic do_alarm;

    assign start        = upd_we && !busy && (upd_wdata.wr || upd_wdata.alm);
    assign snap_en      = upd_we && upd_wdata.rd;
    assign commit_time  = done && wr_flag && ten;
    assign commit_alarm = done && do_alarm;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            wr_flag  <= 1'b0;
            alm_flag <= 1'b0;
            ten      <= 1'b0;
            fast_q   <= 1'b0;
            do_alarm <= 1'b0;
        end else if (done) begin
            busy     <= 1'b0;
            wr_flag  <= 1'b0;
            do_alarm <= 1'b0;
            if (ALARM_AUTOCLEAR) alm_flag <= 1'b0;
        end else if (upd_we && !busy) begin
            busy     <= start;
            wr_flag  <= upd_wdata.wr;
            alm_flag <= upd_wdata.alm;
            do_alarm <= upd_wdata.alm;
            ten      <= upd_wdata.time_en;
            fast_q   <= upd_wdata.fast;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= '0;
            time_load_o  <= 1'b0;
            alarm_load_o <= 1'b0;
        end else begin
            if (ctrl_we) ctrl_q <= ctrl_wdata;
            time_load_o  <= commit_time;
            alarm_load_o <= commit_alarm;
        end
    end

    always_comb begin
        upd_q         = '0;
        upd_q.wr      = wr_flag;
        upd_q.rd      = 1'b0;
        upd_q.alm     = alm_flag;
        upd_q.time_en = ten;
        upd_q.fast    = fast_q;
    end

    AST_WR_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_flag && !done) |=> wr_flag);                 // R3
    AST_WR_CLEARED: assert property (@(posedge clk) disable iff (rst)
        done |=> !wr_flag);                                      // R3
    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        time_load_o |=> !time_load_o);                           // R4
    AST_LOAD_NEEDS_TEN: assert property (@(posedge clk) disable iff (rst)
        time_load_o |-> $past(ten));                             // R5
    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        (busy && upd_we && !done) |=> $stable(do_alarm));        // R7

    if (ALARM_AUTOCLEAR) begin : g_auto
        AST_ALM_SELFCLR: assert property (@(posedge clk) disable iff (rst)
            (done && do_alarm) |=> !alm_flag);                   // R6
    end else begin : g_manual
        AST_ALM_STICKY: assert property (@(posedge clk) disable iff (rst)
            (alm_flag && !upd_we) |=> alm_flag);                 // R6
    end

endmodule

// File: rtl/rtc_shadow_sync.sv
module rtc_shadow_sync
    import rtc_sync_pkg::*;
#(
    parameter int NBYTES          = 8,
    parameter int PRESC_DIV       = 2,
    parameter int DLY_LONG        = 240,
    parameter int DLY_SHORT       = 15,
    parameter bit ALARM_AUTOCLEAR = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_we,
    input  logic [4:0]               host_addr,
    input  logic [7:0]               host_wdata,
    output logic [7:0]               host_rdata,
    input  logic [NBYTES*8-1:0]      live_time_i,
    output logic                     time_load_o,
    output logic [NBYTES*8-1:0]      time_value_o,
    output logic                     alarm_load_o,
    output logic [NBYTES*8-1:0]      alarm_value_o,
    output logic                     bcd_en_o,
    output logic                     hour24_o
);

    dec_t       dec;
    logic       upd_we;
    logic       ctrl_we;
    logic       start;
    logic       done;
    logic       snap_en;
    logic       commit_time;
    logic       commit_alarm;
    upd_reg_t   upd_q;
    ctrl_reg_t  ctrl_q;
    logic [7:0] snap_byte;
    logic [7:0] alarm_byte;

    assign dec     = decode_addr(host_addr, NBYTES);
    assign upd_we  = host_we && (dec.sel == SEL_UPD);
    assign ctrl_we = host_we && (dec.sel == SEL_CTRL);

    rtc_upd_ctrl #(
        .ALARM_AUTOCLEAR(ALARM_AUTOCLEAR)
    ) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .upd_we       (upd_we),
        .upd_wdata    (upd_reg_t'(host_wdata[4:0])),
        .ctrl_we      (ctrl_we),
        .ctrl_wdata   (ctrl_reg_t'(host_wdata[1:0])),
        .done         (done),
        .start        (start),
        .snap_en      (snap_en),
        .commit_time  (commit_time),
        .commit_alarm (commit_alarm),
        .upd_q        (upd_q),
        .ctrl_q       (ctrl_q),
        .time_load_o  (time_load_o),
        .alarm_load_o (alarm_load_o)
    );

    rtc_xfer_timer #(
        .PRESC_DIV (PRESC_DIV),
        .DLY_LONG  (DLY_LONG),
        .DLY_SHORT (DLY_SHORT)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .fast_sel (host_wdata[4]),
        .done     (done)
    );

    rtc_shadow_regs #(
        .NBYTES(NBYTES)
    ) u_regs (
        .clk           (clk),
        .rst           (rst),
        .we            (host_we),
        .dec           (dec),
        .wdata         (host_wdata),
        .snap_en       (snap_en),
        .commit_time   (commit_time),
        .commit_alarm  (commit_alarm),
        .live_time_i   (live_time_i),
        .time_value_o  (time_value_o),
        .alarm_value_o (alarm_value_o),
        .snap_byte     (snap_byte),
        .alarm_byte    (alarm_byte)
    );

    always_comb begin
        unique case (dec.sel)
            SEL_TIME:  host_rdata = snap_byte;
            SEL_ALARM: host_rdata = alarm_byte;
            SEL_UPD:   host_rdata = {3'b000, upd_q};
            SEL_CTRL:  host_rdata = {6'b000000, ctrl_q};
            default:   host_rdata = 8'h00;
        endcase
    end

    assign bcd_en_o = ctrl_q.bcd;
    assign hour24_o = ctrl_q.h24;

    AST_ALOAD_PULSE: assert property (@(posedge clk) disable iff (rst)
        alarm_load_o |=> !alarm_load_o);                         // R6
    AST_CTRL_OUT: assert property (@(posedge clk) disable iff (rst)
        ctrl_we |=> (bcd_en_o == $past(host_wdata[0])));         // R10

endmodule

// File: tb/tb_rtc_shadow_sync.sv
module tb_rtc_shadow_sync;

    localparam int CLK_PERIOD = 10;
    localparam int NB    = 8;
    localparam int DIV   = 2;
    localparam int LONG  = 240;
    localparam int SHORT = 15;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            host_we = 1'b0;
    logic [4:0]      host_addr = '0;
    logic [7:0]      host_wdata = '0;
    logic [7:0]      host_rdata, host_rdata_m;
    logic [NB*8-1:0] cal = '0;
    logic            time_load_o, alarm_load_o, time_load_m, alarm_load_m;
    logic [NB*8-1:0] time_value_o, alarm_value_o, time_value_m, alarm_value_m;
    logic            bcd_en_o, hour24_o, bcd_m, h24_m;

    int n_checks = 0;
    int n_fail   = 0;
    int tl_cnt   = 0;
    int al_cnt   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_shadow_sync #(.NBYTES(NB), .PRESC_DIV(DIV), .DLY_LONG(LONG),
                      .DLY_SHORT(SHORT), .ALARM_AUTOCLEAR(1'b1)) dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .live_time_i(cal),
        .time_load_o(time_load_o), .time_value_o(time_value_o),
        .alarm_load_o(alarm_load_o), .alarm_value_o(alarm_value_o),
        .bcd_en_o(bcd_en_o), .hour24_o(hour24_o));

    rtc_shadow_sync #(.NBYTES(NB), .PRESC_DIV(DIV), .DLY_LONG(LONG),
                      .DLY_SHORT(SHORT), .ALARM_AUTOCLEAR(1'b0)) dut_man (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata_m), .live_time_i(cal),
        .time_load_o(time_load_m), .time_value_o(time_value_m),
        .alarm_load_o(alarm_load_m), .alarm_value_o(alarm_value_m),
        .bcd_en_o(bcd_m), .hour24_o(h24_m));

    // calendar stub: changes shortly after each rising edge
    initial forever begin
        @(posedge clk);
        #2;
        cal = cal + 1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            tl_cnt = tl_cnt + int'(time_load_o);
            al_cnt = al_cnt + int'(alarm_load_o);
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        host_addr  = a;
        host_wdata = d;
        host_we    = 1'b1;
        @(negedge clk);
        host_we    = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d, output logic [7:0] dm);
        host_we   = 1'b0;
        host_addr = a;
        #1;
        d  = host_rdata;
        dm = host_rdata_m;
    endtask

    function automatic logic [63:0] pattern(input logic [7:0] base);
        logic [63:0] p;
        for (int i = 0; i < NB; i++) p[i*8 +: 8] = base + 8'(i);
        return p;
    endfunction

    task automatic t_reset();
        logic [7:0] d, dm;
        rd(5'd16, d, dm);
        chk("R1 upd reg", {56'd0, d}, 64'd0);
        rd(5'd17, d, dm);
        chk("R1 ctrl reg", {56'd0, d}, 64'd0);
        chk("R1 loads", {62'd0, time_load_o, alarm_load_o}, 64'd0);
        chk("R1 time value", time_value_o, 64'd0);
        chk("R1 alarm value", alarm_value_o, 64'd0);
    endtask

    task automatic t_ctrl();
        logic [7:0] d, dm;
        wr(5'd17, 8'h03);
        rd(5'd17, d, dm);
        chk("R10 readback 3", {56'd0, d}, 64'h03);
        chk("R10 outputs", {62'd0, bcd_en_o, hour24_o}, 64'h3);
        @(negedge clk);
        wr(5'd17, 8'h02);
        rd(5'd17, d, dm);
        chk("R10 readback 2", {56'd0, d}, 64'h02);
        chk("R10 outputs 24h only", {62'd0, bcd_en_o, hour24_o}, 64'h1);
    endtask

    task automatic t_alarm_stage();
        logic [7:0] d, dm;
        @(negedge clk);
        for (int i = 0; i < NB; i++) wr(5'(8 + i), 8'h40 + 8'(i));
        for (int i = 0; i < NB; i++) begin
            rd(5'(8 + i), d, dm);
            chk("R11 alarm stage readback", {56'd0, d}, {56'd0, 8'h40 + 8'(i)});
        end
        chk("R2 alarm not live yet", alarm_value_o, 64'd0);
    endtask

    task automatic t_time_long();
        logic [7:0] d, dm;
        @(negedge clk);
        for (int i = 0; i < NB; i++) wr(5'(i), 8'h10 + 8'(i));
        chk("R2 staged time not live", time_value_o, 64'd0);
        wr(5'd16, 8'h09);
        repeat (LONG*DIV - 1) @(negedge clk);
        rd(5'd16, d, dm);
        chk("R3 wr bit held in flight", {63'd0, d[0]}, 64'd1);
        chk("R4 no early load", {63'd0, time_load_o}, 64'd0);
        chk("R2 live unchanged before commit", time_value_o, 64'd0);
        @(negedge clk);
        chk("R4 load pulse at long delay", {63'd0, time_load_o}, 64'd1);
        chk("R4 live value", time_value_o, pattern(8'h10));
        rd(5'd16, d, dm);
        chk("R3 wr bit self-cleared", {63'd0, d[0]}, 64'd0);
        @(negedge clk);
        chk("R4 pulse one cycle", {63'd0, time_load_o}, 64'd0);
    endtask

    task automatic t_short_ignore();
        logic [7:0] d, dm;
        int al0;
        @(negedge clk);
        for (int i = 0; i < NB; i++) wr(5'(i), 8'hA0 + 8'(i));
        al0 = al_cnt;
        wr(5'd16, 8'h19);
        repeat (5) @(negedge clk);
        wr(5'd16, 8'h0D);
        repeat (SHORT*DIV - 7) @(negedge clk);
        chk("R7 no early commit", {63'd0, time_load_o}, 64'd0);
        rd(5'd16, d, dm);
        chk("R7 alarm bit not taken", {63'd0, d[2]}, 64'd0);
        chk("R3 wr bit in short run", {63'd0, d[0]}, 64'd1);
        @(negedge clk);
        chk("R4 load at short delay", {63'd0, time_load_o}, 64'd1);
        chk("R4 short live value", time_value_o, pattern(8'hA0));
        repeat (3) @(negedge clk);
        #1;
        chk("R7 no alarm commit", 64'(al_cnt), 64'(al0));
    endtask

    task automatic t_no_ten();
        logic [7:0] d, dm;
        int tl0;
        @(negedge clk);
        for (int i = 0; i < NB; i++) wr(5'(i), 8'h55);
        tl0 = tl_cnt;
        wr(5'd16, 8'h11);
        repeat (SHORT*DIV + 10) @(negedge clk);
        #1;
        chk("R5 no load without time-enable", 64'(tl_cnt), 64'(tl0));
        chk("R5 live unchanged", time_value_o, pattern(8'hA0));
        rd(5'd16, d, dm);
        chk("R5 transfer finished", {63'd0, d[0]}, 64'd0);
    endtask

    task automatic t_alarm_commit();
        logic [7:0] d, dm;
        int tl0;
        @(negedge clk);
        tl0 = tl_cnt;
        wr(5'd16, 8'h14);
        repeat (SHORT*DIV - 1) @(negedge clk);
        chk("R6 no early alarm load", {63'd0, alarm_load_o}, 64'd0);
        @(negedge clk);
        chk("R6 alarm load pulse", {62'd0, alarm_load_o, alarm_load_m}, 64'h3);
        chk("R6 alarm live value", alarm_value_o, pattern(8'h40));
        chk("R6 alarm live value manual", alarm_value_m, pattern(8'h40));
        repeat (5) @(negedge clk);
        #1;
        chk("R5 alarm-only commit loads no time", 64'(tl_cnt), 64'(tl0));
        rd(5'd16, d, dm);
        chk("R6 auto-cleared alarm bit", {63'd0, d[2]}, 64'd0);
        chk("R6 manual alarm bit sticky", {63'd0, dm[2]}, 64'd1);
        @(negedge clk);
        wr(5'd16, 8'h00);
        rd(5'd16, d, dm);
        chk("R6 manual alarm bit cleared by host", {63'd0, dm[2]}, 64'd0);
    endtask

    task automatic t_snapshot();
        logic [7:0]  d, dm;
        logic [63:0] exp, got;
        @(negedge clk);
        exp = cal;
        wr(5'd16, 8'h02);
        got = '0;
        for (int i = 0; i < NB; i++) begin
            rd(5'(i), d, dm);
            got[i*8 +: 8] = d;
        end
        chk("R8 snapshot equals live at request", got, exp);
        rd(5'd16, d, dm);
        chk("R8 read bit reads 0", {63'd0, d[1]}, 64'd0);
        repeat (20) @(negedge clk);
        got = '0;
        for (int i = 0; i < NB; i++) begin
            rd(5'(i), d, dm);
            got[i*8 +: 8] = d;
        end
        chk("R9 snapshot stable", got, exp);
        chk("R9 live counter moved", {63'd0, cal != exp}, 64'd1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_alarm_stage();
        t_time_long();
        t_short_ignore();
        t_no_ten();
        t_alarm_commit();
        t_snapshot();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule